// File: doc/BRIEF.md
# Hardware Return Stack with Status Pointer

This block is the return stack of a DSP program sequencer. It keeps fifteen 32-bit entries, each made of a 16-bit high half and a 16-bit low half. The high half receives the program counter. The low half receives the status register. When a hardware loop begins, a separate entry first receives the loop address (high half) and the loop count (low half). A 6-bit pointer marks the top entry. Its two upper bits are sticky flags for stack error and underflow.

The sequencer drives push and pull strobes together with an operation code. On a subroutine return or an interrupt return, the block presents the popped halves on restore outputs, with one valid flag per half. A loop start takes two cycles. The first cycle stores the loop address and count. The second cycle stores the program counter and status register that are presented on the data inputs in that cycle. The pointer can be read and loaded directly at any time.

A push beyond the fifteenth entry, or a pull from the empty stack, moves the pointer into an error value and raises a one-cycle stack-error interrupt. Entry location 0 does not exist: a write to it is dropped and a read from it returns zero.

Top module: `ret_stack`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `sp_o` is 0 and `stk_err_irq_o`, `pc_vld_o` and `sr_vld_o` are 0.
- R2: A push with `op_i` equal to 0 (call) or 1 (interrupt), or with any other op apart from 2, stores `hi_i`:`lo_i` into location (`sp_o`+1) modulo 16 and raises `sp_o` by one. `rst_hi_o` and `rst_lo_o` always show the halves at location `sp_o[3:0]`.
- R3: A pull with `op_i` = 3 (return from subroutine) sets `pc_vld_o` only, with `rst_hi_o` holding the top high half, and lowers `sp_o` by one.
- R4: A pull with `op_i` = 4 (return from interrupt) sets both `pc_vld_o` and `sr_vld_o` and lowers `sp_o` by one.
- R5: A pull with any other `op_i` lowers `sp_o` by one and restores nothing: both valid flags stay 0.
- R6: A push with `op_i` = 2 (loop start) stores `hi_i`:`lo_i` in that cycle. In the next cycle the block pushes `hi_i`:`lo_i` again without any strobe, and it ignores push and pull in that second cycle.
- R7: A push at `sp_o` = 15 gives 16. The write to location 0 is dropped, so the restore outputs read 0. A further push gives 17.
- R8: A pull at `sp_o` = 0 gives 63, so bits 5 and 4 are both set. A further pull gives 62. At location 0 the restore outputs read 0.
- R9: `stk_err_irq_o` is high for exactly the one cycle after a clock edge at which `sp_o[4]` changed from 0 to 1, whatever the cause of the change.
- R10: When `sp_we_i` is high, `sp_o` takes `sp_wdata_i` at the next edge. This load overrides push, pull and a pending second loop cycle, which is cancelled.
- R11: When push and pull are both requested in one cycle, the push is performed and the pull is ignored, with no restore flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe |
| pull_i | input | 1 | Pull strobe |
| op_i | input | 3 | Operation: 0 call, 1 interrupt, 2 loop start, 3 subroutine return, 4 interrupt return |
| hi_i | input | 16 | High half to store (program counter or loop address) |
| lo_i | input | 16 | Low half to store (status register or loop count) |
| sp_we_i | input | 1 | Direct pointer load |
| sp_wdata_i | input | 6 | Value loaded into the pointer |
| sp_o | output | 6 | Pointer: bit 5 underflow, bit 4 stack error, bits 3:0 location |
| rst_hi_o | output | 16 | High half of the top entry |
| rst_lo_o | output | 16 | Low half of the top entry |
| pc_vld_o | output | 1 | Restore the program counter from rst_hi_o |
| sr_vld_o | output | 1 | Restore the status register from rst_lo_o |
| stk_err_irq_o | output | 1 | Stack-error interrupt pulse |

## Verification
The bench fills the stack to the fifteenth entry and pushes twice more. A design that wrote location 0 would then return stale data instead of zero, and one that saturated the pointer would stop at 16 instead of reaching 17. It also pulls twice from the empty stack. A design that clamped the pointer would miss the 63 and 62 values, and one that fired the interrupt on every error step would pulse a second time. The bench also covers the second loop cycle, where a design that obeyed strobes would double-move the pointer. Finally, it loads the pointer during a push, a pull and a pending loop cycle, where wrong priority would leave the pointer off by one.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LOC_W  = 4;
  localparam int unsigned PTR_W  = LOC_W + 2;

  typedef enum logic [2:0] {
    OP_CALL = 3'd0,
    OP_INTR = 3'd1,
    OP_LOOP = 3'd2,
    OP_RTS  = 3'd3,
    OP_RTI  = 3'd4
  } rs_op_e;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       pull_i,
  input  logic [2:0] op_i,
  input  logic       sp_we_i,
  output logic       mv_push_o,
  output logic       mv_pull_o,
  output logic       pc_vld_o,
  output logic       sr_vld_o
);
  logic pend_q, pend_d;
  logic is_rts, is_rti;

  assign is_rts = (op_i == OP_RTS);
  assign is_rti = (op_i == OP_RTI);

  // second loop beat owns the cycle unless the pointer is being loaded
  always_comb begin
    mv_push_o = 1'b0;
    mv_pull_o = 1'b0;
    pend_d    = 1'b0;
    if (!sp_we_i) begin
      if (pend_q) begin
        mv_push_o = 1'b1;
      end else if (push_i) begin
        mv_push_o = 1'b1;
        pend_d    = (op_i == OP_LOOP);
      end else if (pull_i) begin
        mv_pull_o = 1'b1;
      end
    end
  end

  assign pc_vld_o = mv_pull_o && (is_rts || is_rti);
  assign sr_vld_o = mv_pull_o && is_rti;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  p_beat_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !pend_q);
  p_beat_pushes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !sp_we_i) |-> (mv_push_o && !mv_pull_o));
  p_push_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!pc_vld_o && !sr_vld_o));
  p_rts_pc_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_vld_o && op_i == OP_RTS) |-> !sr_vld_o);
endmodule

// File: rtl/rs_ptr.sv
module rs_ptr
  import rs_pkg::*;
#(
  parameter int unsigned PW = PTR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mv_push_i,
  input  logic          mv_pull_i,
  input  logic          sp_we_i,
  input  logic [PW-1:0] sp_wdata_i,
  output logic [PW-1:0] sp_o,
  output logic          irq_o
);
  localparam int unsigned ERR_BIT = PW - 2;

  logic [PW-1:0] sp_q, sp_d;
  logic          irq_q;

  always_comb begin
    sp_d = sp_q;
    if (sp_we_i)        sp_d = sp_wdata_i;
    else if (mv_push_i) sp_d = sp_q + PW'(1);
    else if (mv_pull_i) sp_d = sp_q - PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      sp_q  <= sp_d;
      irq_q <= sp_d[ERR_BIT] && !sp_q[ERR_BIT];
    end
  end

  assign sp_o  = sp_q;
  assign irq_o = irq_q;

  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_i |=> sp_q == $past(sp_wdata_i));
  p_push_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv_push_i && !sp_we_i) |=> sp_q == $past(sp_q) + PW'(1));
  p_pull_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv_pull_i && !sp_we_i) |=> sp_q == $past(sp_q) - PW'(1));
  p_irq_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  p_irq_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> sp_q[ERR_BIT]);
endmodule

// File: rtl/rs_mem.sv
module rs_mem
  import rs_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned LW = LOC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [LW-1:0] wr_loc_i,
  input  logic [DW-1:0] wr_hi_i,
  input  logic [DW-1:0] wr_lo_i,
  input  logic [LW-1:0] rd_loc_i,
  output logic [DW-1:0] rd_hi_o,
  output logic [DW-1:0] rd_lo_o
);
  localparam int unsigned NLOC  = 1 << LW;
  localparam int unsigned DEPTH = NLOC - 1;

  logic [DW-1:0] hi_q [NLOC];
  logic [DW-1:0] lo_q [NLOC];

  // location 0 has no storage and reads as zero
  assign hi_q[0] = '0;
  assign lo_q[0] = '0;

  for (genvar g = 1; g <= DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q[g] <= '0;
        lo_q[g] <= '0;
      end else if (wr_en_i && wr_loc_i == LW'(g)) begin
        hi_q[g] <= wr_hi_i;
        lo_q[g] <= wr_lo_i;
      end
    end
  end

  assign rd_hi_o = hi_q[rd_loc_i];
  assign rd_lo_o = lo_q[rd_loc_i];

  p_phantom_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_loc_i == '0) |-> (rd_hi_o == '0 && rd_lo_o == '0));
  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_loc_i != '0 && rd_loc_i == wr_loc_i - LW'(1)) |=>
      (hi_q[$past(wr_loc_i)] == $past(wr_hi_i)));
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import rs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pull_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic              sp_we_i,
  input  logic [PTR_W-1:0]  sp_wdata_i,
  output logic [PTR_W-1:0]  sp_o,
  output logic [DATA_W-1:0] rst_hi_o,
  output logic [DATA_W-1:0] rst_lo_o,
  output logic              pc_vld_o,
  output logic              sr_vld_o,
  output logic              stk_err_irq_o
);
  logic             mv_push, mv_pull;
  logic [LOC_W-1:0] top_loc, new_loc;

  rs_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push_i),
    .pull_i    (pull_i),
    .op_i      (op_i),
    .sp_we_i   (sp_we_i),
    .mv_push_o (mv_push),
    .mv_pull_o (mv_pull),
    .pc_vld_o  (pc_vld_o),
    .sr_vld_o  (sr_vld_o)
  );

  rs_ptr #(.PW(PTR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mv_push_i  (mv_push),
    .mv_pull_i  (mv_pull),
    .sp_we_i    (sp_we_i),
    .sp_wdata_i (sp_wdata_i),
    .sp_o       (sp_o),
    .irq_o      (stk_err_irq_o)
  );

  assign top_loc = sp_o[LOC_W-1:0];
  assign new_loc = top_loc + LOC_W'(1);

  rs_mem #(.DW(DATA_W), .LW(LOC_W)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (mv_push),
    .wr_loc_i (new_loc),
    .wr_hi_i  (hi_i),
    .wr_lo_i  (lo_i),
    .rd_loc_i (top_loc),
    .rd_hi_o  (rst_hi_o),
    .rd_lo_o  (rst_lo_o)
  );
endmodule

// File: tb/ret_stack_tb_top.sv
module ret_stack_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0, pull_i = 1'b0, sp_we_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] hi_i = '0, lo_i = '0;
  logic [5:0]  sp_wdata_i = '0;
  logic [5:0]  sp_o;
  logic [15:0] rst_hi_o, rst_lo_o;
  logic        pc_vld_o, sr_vld_o, stk_err_irq_o;

  int vectors = 0;
  int miscmp  = 0;

  // reference model
  logic [15:0] m_hi [16];
  logic [15:0] m_lo [16];
  int          m_sp   = 0;
  bit          m_pend = 0;
  bit          m_irq  = 0;

  always #10 clk = ~clk;

  ret_stack dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .pull_i(pull_i), .op_i(op_i),
    .hi_i(hi_i), .lo_i(lo_i), .sp_we_i(sp_we_i), .sp_wdata_i(sp_wdata_i),
    .sp_o(sp_o), .rst_hi_o(rst_hi_o), .rst_lo_o(rst_lo_o), .pc_vld_o(pc_vld_o),
    .sr_vld_o(sr_vld_o), .stk_err_irq_o(stk_err_irq_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit we, input int wd, input bit ps,
                      input bit pl, input int op, input int hi, input int lo);
    bit mv_ps, mv_pl, e_pc, e_sr, n_pend;
    int loc, nsp;
    @(negedge clk);
    sp_we_i = we; sp_wdata_i = 6'(wd); push_i = ps; pull_i = pl;
    op_i = 3'(op); hi_i = 16'(hi); lo_i = 16'(lo);
    #5;
    mv_ps = 0; mv_pl = 0; n_pend = 0;
    if (!we) begin
      if (m_pend) mv_ps = 1;
      else if (ps) begin mv_ps = 1; n_pend = (op == 2); end
      else if (pl) mv_pl = 1;
    end
    e_pc = mv_pl && (op == 3 || op == 4);
    e_sr = mv_pl && (op == 4);
    loc = m_sp % 16;
    chk(tag, "sp", sp_o, m_sp);
    chk(tag, "irq", stk_err_irq_o, m_irq);
    chk(tag, "pc_vld", pc_vld_o, e_pc);
    chk(tag, "sr_vld", sr_vld_o, e_sr);
    chk(tag, "hi", rst_hi_o, (loc == 0) ? 0 : m_hi[loc]);
    chk(tag, "lo", rst_lo_o, (loc == 0) ? 0 : m_lo[loc]);
    @(posedge clk);
    nsp = m_sp;
    if (we) nsp = wd;
    else if (mv_ps) begin
      if (((m_sp + 1) % 16) != 0) begin
        m_hi[(m_sp + 1) % 16] = 16'(hi);
        m_lo[(m_sp + 1) % 16] = 16'(lo);
      end
      nsp = (m_sp + 1) % 64;
    end else if (mv_pl) nsp = (m_sp + 63) % 64;
    m_irq  = ((nsp & 16) != 0) && ((m_sp & 16) == 0);
    m_sp   = nsp;
    m_pend = n_pend;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    miscmp++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
    // R1 during reset
    #15;
    chk("R1", "sp_rst", sp_o, 0);
    chk("R1", "irq_rst", stk_err_irq_o, 0);
    chk("R1", "pc_vld_rst", pc_vld_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    idle("R1");
    // R2 calls and interrupts
    step("R2", 0, 0, 1, 0, 0, 'h1111, 'h0a01);
    step("R2", 0, 0, 1, 0, 1, 'h2222, 'h0a02);
    step("R2", 0, 0, 1, 0, 0, 'h3333, 'h0a03);
    idle("R2");
    // R3, R4, R5 pulls
    step("R3", 0, 0, 0, 1, 3, 0, 0);
    step("R4", 0, 0, 0, 1, 4, 0, 0);
    step("R5", 0, 0, 0, 1, 0, 0, 0);
    idle("R5");
    // R6 loop start: second cycle strobes are ignored
    step("R6", 0, 0, 1, 0, 2, 'h4000, 'h0007);
    step("R6", 0, 0, 0, 1, 3, 'h4444, 'h0b00);
    idle("R6");
    step("R6", 0, 0, 1, 0, 2, 'h5000, 'h0003);
    step("R6", 0, 0, 1, 0, 2, 'h5555, 'h0c00);
    idle("R6");
    step("R4", 0, 0, 0, 1, 4, 0, 0);
    step("R3", 0, 0, 0, 1, 3, 0, 0);
    // R11 push beats pull
    step("R11", 0, 0, 1, 1, 3, 'h6666, 'h0d00);
    idle("R11");
    // R7 overflow
    step("R10", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 1; i <= 15; i++) step("R2", 0, 0, 1, 0, 0, 'h7000 + i, 'h0e00 + i);
    idle("R7");
    step("R7", 0, 0, 1, 0, 0, 'hdead, 'hbeef);
    idle("R7");
    step("R9", 0, 0, 1, 0, 1, 'h7777, 'h0f00);
    idle("R9");
    idle("R7");
    // R8 underflow
    step("R10", 1, 0, 0, 0, 0, 0, 0);
    idle("R8");
    step("R8", 0, 0, 0, 1, 3, 0, 0);
    idle("R9");
    step("R8", 0, 0, 0, 1, 5, 0, 0);
    idle("R8");
    // R10 load priority
    step("R10", 1, 5, 1, 0, 0, 'h1234, 'h5678);
    step("R10", 1, 9, 0, 1, 4, 0, 0);
    step("R10", 0, 0, 1, 0, 2, 'h8000, 'h0002);
    step("R10", 1, 2, 1, 0, 0, 'h9999, 'h9999);
    idle("R10");
    step("R9", 1, 20, 0, 0, 0, 0, 0);
    idle("R9");
    idle("R9");
    step("R10", 1, 3, 0, 0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 31));
      if (r == 0)
        step("R10", 1, int'($urandom_range(0, 63)), 1, 0, 0, 0, 0);
      else if (r < 14)
        step("R2", 0, 0, 1, r[0], int'($urandom_range(0, 4)),
             int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)));
      else if (r < 27)
        step("R5", 0, 0, 0, 1, int'($urandom_range(0, 7)), 0, 0);
      else
        idle("R1");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule